// File: doc/BRIEF.md
# Multichannel CIC Decimator

This block lowers the sample rate of several time-interleaved signals that share one data input. Each channel passes through N cascaded running-sum stages at the input rate. A down-sampler by R follows, then N difference stages at the reduced rate, each with a differential delay of M. All of it uses adders and subtractors only. The arithmetic is shared among the channels. Per-channel state is held in register arrays indexed by the channel of the current sample.

Samples are qualified by a valid input, which may stay high or pulse. A block-start input marks the sample of channel 0; any other accepted sample belongs to the channel after the previous one. The rate and the delay can be changed while running. Each has a value port and a load strobe. A loaded value waits as pending until the next accepted block-start sample, which applies it. The output is the full internal width and comes with a valid flag and a channel-0 marker. A clock enable and a synchronous clear complete the control.

Top module: `cic_decim_mc`

## Requirements
- R1: Each channel keeps N running sums, and the first takes the sign-extended input. On every accepted sample, stage k adds the new value of stage k-1 to its own value. All arithmetic wraps in two's complement at ACC_W = DATA_W + N*ceil(log2(MAX_RATE*MAX_DLY)) bits.
- R2: An accepted sample (in_valid_i high) with in_start_i high is channel 0. Any other accepted sample is the channel after the last accepted one, wrapping after CHANNELS-1. Cycles with in_valid_i low change no state.
- R3: Every R-th accepted sample of a channel closes a decimation window. One clock later, out_valid_o is high for exactly one cycle. Between outputs, dout_o holds its last value.
- R4: At a window close, the last running sum passes through N difference stages, y = x[k] - x[k-M], on that channel's decimated sequence. History is zero until written. With constant input u, the settled output is u*(R*M)^N.
- R5: A rate strobe loads rate_i as pending only if 2 <= rate_i <= MAX_RATE. A delay strobe loads dly_i as pending only if 1 <= dly_i <= MAX_DLY. Out-of-range values are ignored, and the active settings stay in those ranges.
- R6: The next accepted block-start sample applies any pending value. It restarts all channels' window counters with itself as the first sample and zeroes all difference-stage history. Running sums are kept. A strobe in that same cycle is applied only at the following block-start sample.
- R7: out_start_o is high together with out_valid_o exactly when the output belongs to channel 0.
- R8: While ce_i is low, every register holds, and all inputs, strobes included, are ignored.
- R9: clear_i with ce_i high zeroes the running sums, history, window counters, channel pointer and outputs, and drops the sample of that cycle. Active and pending settings are kept.
- R10: rst_ni low zeroes all state and outputs asynchronously, sets the rate to DEF_RATE and the delay to DEF_DLY, and discards anything pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Clock enable, freezes the block when low |
| clear_i | input | 1 | Synchronous clear, effective with ce_i high |
| din_i | input | DATA_W | Signed input sample |
| in_valid_i | input | 1 | Input sample qualifier |
| in_start_i | input | 1 | Marks the channel-0 sample |
| rate_i | input | RATE_W | Rate factor value |
| rate_set_i | input | 1 | Load strobe for rate_i |
| dly_i | input | DLY_W | Differential delay value |
| dly_set_i | input | 1 | Load strobe for dly_i |
| dout_o | output | ACC_W | Full-precision signed output |
| out_valid_o | output | 1 | Output word valid |
| out_start_o | output | 1 | Output word belongs to channel 0 |

## Verification
The risky overlap is a load strobe arriving in the same cycle as the block-start sample that applies an earlier pending value. The bench provokes it by strobing a new rate and delay exactly on a channel-0 sample while other values wait. A reference model of queues and integers, updated on every clock, predicts that the value just strobed waits for the following block start. Output counts over fixed windows and the settled gain u*(R*M)^N show which rate and delay are actually in force.

// File: rtl/cic_pkg.sv
package cic_pkg;
  function automatic int acc_width(int dw, int st, int mr, int md);
    return dw + st * $clog2(mr * md);
  endfunction

  function automatic int idx_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl #(
  parameter int CHANNELS = 2,
  parameter int MAX_RATE = 16,
  parameter int MAX_DLY  = 4,
  parameter int DEF_RATE = 4,
  parameter int DEF_DLY  = 1,
  parameter int CH_W     = 1,
  parameter int RATE_W   = 5,
  parameter int DLY_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              clr_i,
  input  logic              vld_i,
  input  logic              start_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              rate_set_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic              dly_set_i,
  output logic [CH_W-1:0]   ch_o,
  output logic              fire_o,
  output logic              flush_o,
  output logic [DLY_W-1:0]  dly_eff_o,
  output logic [RATE_W-1:0] rate_cur_o,
  output logic [DLY_W-1:0]  dly_cur_o
);
  logic [CH_W-1:0]   ptr_q;
  logic [RATE_W-1:0] phase_q [CHANNELS];
  logic [RATE_W-1:0] rate_q, rate_pend_q, rate_eff, ph_eff;
  logic [DLY_W-1:0]  dly_q, dly_pend_q;
  logic              rate_pv_q, dly_pv_q;
  logic              rate_ok, dly_ok;

  assign rate_ok = rate_set_i && rate_i >= RATE_W'(2) && rate_i <= RATE_W'(MAX_RATE);
  assign dly_ok  = dly_set_i && dly_i >= DLY_W'(1) && dly_i <= DLY_W'(MAX_DLY);

  assign flush_o   = vld_i && start_i && (rate_pv_q || dly_pv_q);
  assign ch_o      = start_i ? '0 : ptr_q;
  assign rate_eff  = (flush_o && rate_pv_q) ? rate_pend_q : rate_q;
  assign dly_eff_o = (flush_o && dly_pv_q) ? dly_pend_q : dly_q;
  assign ph_eff    = flush_o ? '0 : phase_q[ch_o];
  assign fire_o    = vld_i && (ph_eff == rate_eff - RATE_W'(1));

  assign rate_cur_o = rate_q;
  assign dly_cur_o  = dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      rate_q      <= RATE_W'(DEF_RATE);
      dly_q       <= DLY_W'(DEF_DLY);
      rate_pend_q <= '0;
      dly_pend_q  <= '0;
      rate_pv_q   <= 1'b0;
      dly_pv_q    <= 1'b0;
      for (int c = 0; c < CHANNELS; c++) phase_q[c] <= '0;
    end else if (ce_i) begin
      if (clr_i) begin
        ptr_q <= '0;
        for (int c = 0; c < CHANNELS; c++) phase_q[c] <= '0;
      end else begin
        if (flush_o) begin
          rate_q <= rate_eff;
          dly_q  <= dly_eff_o;
          for (int c = 0; c < CHANNELS; c++) phase_q[c] <= '0;
        end
        if (vld_i) begin
          phase_q[ch_o] <= fire_o ? '0 : ph_eff + RATE_W'(1);
          ptr_q         <= (ch_o == CH_W'(CHANNELS - 1)) ? '0 : ch_o + CH_W'(1);
        end
        if (rate_ok) begin
          rate_pend_q <= rate_i;
          rate_pv_q   <= 1'b1;
        end else if (flush_o) begin
          rate_pv_q   <= 1'b0;
        end
        if (dly_ok) begin
          dly_pend_q <= dly_i;
          dly_pv_q   <= 1'b1;
        end else if (flush_o) begin
          dly_pv_q   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cic_integ_bank.sv
module cic_integ_bank #(
  parameter int ACC_W    = 26,
  parameter int STAGES   = 3,
  parameter int CHANNELS = 2,
  parameter int CH_W     = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ce_i,
  input  logic                    clr_i,
  input  logic                    wr_i,
  input  logic [CH_W-1:0]         ch_i,
  input  logic signed [ACC_W-1:0] x_i,
  output logic signed [ACC_W-1:0] sum_o
);
  logic signed [ACC_W-1:0] acc_q [CHANNELS][STAGES];
  logic signed [ACC_W-1:0] nxt   [STAGES+1];

  assign nxt[0] = x_i;
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    assign nxt[s+1] = acc_q[ch_i][s] + nxt[s];
  end
  assign sum_o = nxt[STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < CHANNELS; c++)
        for (int s = 0; s < STAGES; s++) acc_q[c][s] <= '0;
    end else if (ce_i) begin
      if (clr_i) begin
        for (int c = 0; c < CHANNELS; c++)
          for (int s = 0; s < STAGES; s++) acc_q[c][s] <= '0;
      end else if (wr_i) begin
        for (int s = 0; s < STAGES; s++) acc_q[ch_i][s] <= nxt[s+1];
      end
    end
  end
endmodule

// File: rtl/cic_comb_bank.sv
module cic_comb_bank #(
  parameter int ACC_W    = 26,
  parameter int STAGES   = 3,
  parameter int CHANNELS = 2,
  parameter int MAX_DLY  = 4,
  parameter int CH_W     = 1,
  parameter int DLY_W    = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ce_i,
  input  logic                    clr_i,
  input  logic                    flush_i,
  input  logic                    wr_i,
  input  logic [CH_W-1:0]         ch_i,
  input  logic [DLY_W-1:0]        dly_i,
  input  logic signed [ACC_W-1:0] x_i,
  output logic signed [ACC_W-1:0] y_o
);
  localparam int TAP_W = cic_pkg::idx_width(MAX_DLY);

  logic signed [ACC_W-1:0] hist_q [CHANNELS][STAGES][MAX_DLY];
  logic signed [ACC_W-1:0] stg    [STAGES+1];
  logic [TAP_W-1:0]        tap_idx;

  assign tap_idx = TAP_W'(dly_i - DLY_W'(1));
  assign stg[0]  = x_i;
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic signed [ACC_W-1:0] tap;
    assign tap      = flush_i ? '0 : hist_q[ch_i][s][tap_idx];
    assign stg[s+1] = stg[s] - tap;
  end
  assign y_o = stg[STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < CHANNELS; c++)
        for (int s = 0; s < STAGES; s++)
          for (int j = 0; j < MAX_DLY; j++) hist_q[c][s][j] <= '0;
    end else if (ce_i) begin
      if (clr_i) begin
        for (int c = 0; c < CHANNELS; c++)
          for (int s = 0; s < STAGES; s++)
            for (int j = 0; j < MAX_DLY; j++) hist_q[c][s][j] <= '0;
      end else begin
        if (flush_i) begin
          for (int c = 0; c < CHANNELS; c++)
            for (int s = 0; s < STAGES; s++)
              for (int j = 0; j < MAX_DLY; j++) hist_q[c][s][j] <= '0;
        end
        if (wr_i) begin
          for (int s = 0; s < STAGES; s++) begin
            hist_q[ch_i][s][0] <= stg[s];
            for (int j = 1; j < MAX_DLY; j++)
              hist_q[ch_i][s][j] <= flush_i ? '0 : hist_q[ch_i][s][j-1];
          end
        end
      end
    end
  end
endmodule

// File: rtl/cic_decim_mc.sv
module cic_decim_mc #(
  parameter int DATA_W   = 8,
  parameter int STAGES   = 3,
  parameter int CHANNELS = 2,
  parameter int MAX_RATE = 16,
  parameter int MAX_DLY  = 4,
  parameter int DEF_RATE = 4,
  parameter int DEF_DLY  = 1,
  localparam int RATE_W  = $clog2(MAX_RATE + 1),
  localparam int DLY_W   = $clog2(MAX_DLY + 1),
  localparam int ACC_W   = cic_pkg::acc_width(DATA_W, STAGES, MAX_RATE, MAX_DLY)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              in_valid_i,
  input  logic              in_start_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              rate_set_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic              dly_set_i,
  output logic [ACC_W-1:0]  dout_o,
  output logic              out_valid_o,
  output logic              out_start_o
);
  localparam int CH_W = cic_pkg::idx_width(CHANNELS);

  logic [CH_W-1:0]         ch;
  logic                    fire, flush;
  logic [DLY_W-1:0]        dly_eff, dly_cur;
  logic [RATE_W-1:0]       rate_cur;
  logic signed [ACC_W-1:0] x_ext, int_sum, comb_y;

  assign x_ext = {{(ACC_W-DATA_W){din_i[DATA_W-1]}}, din_i};

  cic_ctrl #(
    .CHANNELS(CHANNELS), .MAX_RATE(MAX_RATE), .MAX_DLY(MAX_DLY),
    .DEF_RATE(DEF_RATE), .DEF_DLY(DEF_DLY), .CH_W(CH_W),
    .RATE_W(RATE_W), .DLY_W(DLY_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .ce_i, .clr_i(clear_i),
    .vld_i(in_valid_i), .start_i(in_start_i),
    .rate_i, .rate_set_i, .dly_i, .dly_set_i,
    .ch_o(ch), .fire_o(fire), .flush_o(flush), .dly_eff_o(dly_eff),
    .rate_cur_o(rate_cur), .dly_cur_o(dly_cur)
  );

  cic_integ_bank #(
    .ACC_W(ACC_W), .STAGES(STAGES), .CHANNELS(CHANNELS), .CH_W(CH_W)
  ) u_integ (
    .clk_i, .rst_ni, .ce_i, .clr_i(clear_i), .wr_i(in_valid_i),
    .ch_i(ch), .x_i(x_ext), .sum_o(int_sum)
  );

  cic_comb_bank #(
    .ACC_W(ACC_W), .STAGES(STAGES), .CHANNELS(CHANNELS), .MAX_DLY(MAX_DLY),
    .CH_W(CH_W), .DLY_W(DLY_W)
  ) u_comb (
    .clk_i, .rst_ni, .ce_i, .clr_i(clear_i), .flush_i(flush), .wr_i(fire),
    .ch_i(ch), .dly_i(dly_eff), .x_i(int_sum), .y_o(comb_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o      <= '0;
      out_valid_o <= 1'b0;
      out_start_o <= 1'b0;
    end else if (ce_i) begin
      if (clear_i) begin
        dout_o      <= '0;
        out_valid_o <= 1'b0;
        out_start_o <= 1'b0;
      end else begin
        out_valid_o <= fire;
        out_start_o <= fire && (ch == '0);
        if (fire) dout_o <= comb_y;
      end
    end
  end
endmodule

// File: rtl/cic_decim_mc_sva.sv
module cic_decim_mc_sva #(
  parameter int RATE_W   = 5,
  parameter int DLY_W    = 3,
  parameter int ACC_W    = 26,
  parameter int MAX_RATE = 16,
  parameter int MAX_DLY  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_i,
  input logic              clear_i,
  input logic              in_valid_i,
  input logic [ACC_W-1:0]  dout_o,
  input logic              out_valid_o,
  input logic              out_start_o,
  input logic [RATE_W-1:0] rate_cur,
  input logic [DLY_W-1:0]  dly_cur
);
  assert_start_has_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_start_o |-> out_valid_o);

  assert_valid_from_sample_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(ce_i)) |-> $past(in_valid_i && !clear_i));

  assert_frozen_when_disabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!ce_i) |-> ($stable(dout_o) && $stable(out_valid_o) && $stable(out_start_o)));

  assert_clear_zeroes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ce_i && clear_i) |-> (!out_valid_o && !out_start_o && dout_o == '0));

  assert_settings_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_cur >= RATE_W'(2)) && (rate_cur <= RATE_W'(MAX_RATE)) &&
    (dly_cur >= DLY_W'(1)) && (dly_cur <= DLY_W'(MAX_DLY)));
endmodule

bind cic_decim_mc cic_decim_mc_sva #(
  .RATE_W(RATE_W), .DLY_W(DLY_W), .ACC_W(ACC_W),
  .MAX_RATE(MAX_RATE), .MAX_DLY(MAX_DLY)
) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .clear_i(clear_i),
  .in_valid_i(in_valid_i), .dout_o(dout_o), .out_valid_o(out_valid_o),
  .out_start_o(out_start_o), .rate_cur(rate_cur), .dly_cur(dly_cur)
);

// File: tb/cic_decim_mc_test.sv
module cic_decim_mc_test;
  localparam int DW = 8;
  localparam int N  = 3;
  localparam int C  = 2;
  localparam int MR = 16;
  localparam int MD = 4;
  localparam int AW = DW + N * $clog2(MR * MD);
  localparam int RW = $clog2(MR + 1);
  localparam int LW = $clog2(MD + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b1, clr = 1'b0, vld = 1'b0, st = 1'b0, rset = 1'b0, dset = 1'b0;
  logic [DW-1:0] din = '0;
  logic [RW-1:0] rate = '0;
  logic [LW-1:0] dly = '0;
  logic [AW-1:0] dout;
  logic ovld, ostart;

  always #2.5 clk = ~clk;

  cic_decim_mc #(.DATA_W(DW), .STAGES(N), .CHANNELS(C), .MAX_RATE(MR),
                 .MAX_DLY(MD), .DEF_RATE(4), .DEF_DLY(1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .clear_i(clr), .din_i(din),
    .in_valid_i(vld), .in_start_i(st), .rate_i(rate), .rate_set_i(rset),
    .dly_i(dly), .dly_set_i(dset), .dout_o(dout), .out_valid_o(ovld),
    .out_start_o(ostart));

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R10";

  // reference model
  logic [AW-1:0] m_int [C][N];
  logic [AW-1:0] hq [C*N][$];
  int m_phase [C];
  int m_ptr, m_rate, m_dly, p_rate, p_dly;
  bit p_rv, p_dv;
  bit e_vld, e_st;
  logic [AW-1:0] e_dout;

  task automatic model_reset();
    for (int c = 0; c < C; c++) begin
      m_phase[c] = 0;
      for (int s = 0; s < N; s++) begin m_int[c][s] = '0; hq[c*N+s].delete(); end
    end
    m_ptr = 0; e_vld = 0; e_st = 0; e_dout = '0;
  endtask

  task automatic model_step();
    bit apply, ev;
    int ch, ph;
    logic [AW-1:0] x, tp;
    if (!ce) return;
    if (clr) begin model_reset(); return; end
    ev = 0; ch = 0;
    apply = vld && st && (p_rv || p_dv);
    if (apply) begin
      if (p_rv) m_rate = p_rate;
      if (p_dv) m_dly = p_dly;
      p_rv = 0; p_dv = 0;
      for (int c = 0; c < C; c++) begin
        m_phase[c] = 0;
        for (int s = 0; s < N; s++) hq[c*N+s].delete();
      end
    end
    if (vld) begin
      ch = st ? 0 : m_ptr;
      x = {{(AW-DW){din[DW-1]}}, din};
      for (int s = 0; s < N; s++) begin
        m_int[ch][s] = m_int[ch][s] + x;
        x = m_int[ch][s];
      end
      ph = m_phase[ch];
      if (ph == m_rate - 1) begin
        ev = 1; m_phase[ch] = 0;
        for (int s = 0; s < N; s++) begin
          tp = (hq[ch*N+s].size() >= m_dly) ? hq[ch*N+s][m_dly-1] : '0;
          hq[ch*N+s].push_front(x);
          if (hq[ch*N+s].size() > MD) void'(hq[ch*N+s].pop_back());
          x = x - tp;
        end
        e_dout = x;
      end else m_phase[ch] = ph + 1;
      m_ptr = (ch + 1) % C;
    end
    e_vld = ev; e_st = ev && ch == 0;
    if (rset && rate >= 2 && rate <= MR) begin p_rate = int'(rate); p_rv = 1; end
    if (dset && dly >= 1 && dly <= MD) begin p_dly = int'(dly); p_dv = 1; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset(); m_rate = 4; m_dly = 1; p_rv = 0; p_dv = 0; p_rate = 0; p_dly = 0;
    end else model_step();
  end

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic [AW-1:0] last0, last1;
  int ocount = 0;

  task automatic tick();
    @(negedge clk);
    chk(tag, {ovld, ostart, dout[AW-3:0]}, {e_vld, e_st, e_dout[AW-3:0]});
    chk(tag, dout, e_dout);
    if (ovld) begin
      ocount++;
      if (ostart) last0 = dout; else last1 = dout;
    end
  endtask

  int nxt_ch = 0;
  task automatic send(logic [DW-1:0] d0, logic [DW-1:0] d1, bit v);
    vld = v;
    st = v && nxt_ch == 0;
    din = (nxt_ch == 0) ? d0 : d1;
    if (v) nxt_ch = (nxt_ch + 1) % C;
    tick();
    vld = 0; st = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", {dout[AW-3:0], ovld, ostart}, '0);
    rst_n = 1'b1;
    tick();

    // R1 R2 R4 R7: continuous interleaved constants, rate 4, delay 1
    tag = "R1/R2/R4/R7";
    for (int i = 0; i < 120; i++) send(8'd3, 8'hFE, 1);
    chk("R4", last0, AW'(192));
    chk("R4", last1, AW'(-128));

    // R2 R3: intermittent valid, random data
    tag = "R2/R3";
    for (int i = 0; i < 200; i++) send(8'($urandom), 8'($urandom), ($urandom % 2) == 0);

    // R5: out-of-range loads ignored, then rate 4 still in force
    tag = "R5";
    rate = 5'd1; rset = 1; send(8'd1, 8'd1, 1); rset = 0;
    rate = 5'd17; rset = 1; send(8'd1, 8'd1, 1); rset = 0;
    dly = 3'd0; dset = 1; send(8'd1, 8'd1, 1); dset = 0;
    dly = 3'd5; dset = 1; send(8'd1, 8'd1, 1); dset = 0;
    while (nxt_ch != 0) send(8'd1, 8'd1, 1);
    ocount = 0;
    for (int i = 0; i < 80; i++) send(8'd1, 8'd1, 1);
    chk("R5", AW'(ocount), AW'(20));

    // R6: load rate 8 delay 2; strobe on a block-start sample that applies an older pending value
    tag = "R6";
    rate = 5'd2; rset = 1; send(8'd1, 8'd1, 1); rset = 0;
    while (nxt_ch != 0) send(8'd1, 8'd1, 1);
    rate = 5'd8; rset = 1; dly = 3'd2; dset = 1;
    send(8'd1, 8'd1, 1);
    rset = 0; dset = 0;
    send(8'd1, 8'd1, 1);
    send(8'd1, 8'd1, 1);
    ocount = 0;
    for (int i = 0; i < 160; i++) send(8'd1, 8'd1, 1);
    chk("R6", AW'(ocount), AW'(20));
    for (int i = 0; i < 160; i++) send(8'd1, 8'd1, 1);
    chk("R6", last0, AW'(4096));
    chk("R4", last1, AW'(4096));

    // R8: clock enable low freezes, strobes ignored meanwhile
    tag = "R8";
    for (int i = 0; i < 200; i++) begin
      ce = ($urandom % 2) == 0;
      rate = 5'd2; rset = !ce;
      send(8'($urandom), 8'($urandom), 1);
      rset = 0;
    end
    ce = 1;
    for (int i = 0; i < 40; i++) send(8'd2, 8'd5, 1);

    // R9: clear with a valid sample in the same cycle
    tag = "R9";
    clr = 1; send(8'd7, 8'd7, 1); clr = 0;
    chk("R9", {dout[AW-3:0], ovld, ostart}, '0);
    nxt_ch = 0;
    for (int i = 0; i < 100; i++) send(8'($urandom), 8'($urandom), 1);

    // R10: asynchronous reset mid-stream restores defaults
    tag = "R10";
    @(negedge clk); #1 rst_n = 1'b0; #1;
    chk("R10", {dout[AW-3:0], ovld, ostart}, '0);
    @(negedge clk); rst_n = 1'b1;
    nxt_ch = 0; ocount = 0;
    for (int i = 0; i < 80; i++) send(8'd1, 8'd1, 1);
    chk("R10", AW'(ocount), AW'(20));

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule